// File: doc/BRIEF.md
# Programmable Pulse-Swallow Frequency Divider

This block divides a stream of input ticks by a programmable ratio N = 16·M + A. It is built the way a high-speed RF divider is: a prescaler that divides by 16 or by 17, an A counter that sets how many prescaler periods use the longer modulus, and an M counter that sets how many prescaler periods make one output period. The input arrives as a single-cycle tick (a clock enable) in the system clock domain. For each N ticks the block emits one single-cycle output tick. A divide-by-two square wave, which toggles on every output tick, serves as a test observation signal.

The ratio is supplied as a 15-bit word and captured into a shadow register by a load strobe. The counters take the shadow value only when a full output period ends, so a ratio change never cuts short the period in progress. Ratios below 240 are raised to 240. This floor also guarantees that A never exceeds M, which the swallow scheme needs. The modulus-control signal is brought out so that the prescaler mode can be observed.

Top module: `pulse_swallow_div`

## Requirements
- R1: The ratio word splits into M = bits [14:4] and A = bits [3:0]. Between consecutive output ticks there are exactly 16·M + A input ticks.
- R2: `mod_ctl` is high during the first 17·A input ticks of each output period and low during the remaining ticks. It rises only when a new period starts.
- R3: `out_tick` is a one-cycle pulse. It is high in the cycle after the clock edge that samples the input tick completing the period.
- R4: `half_out` is low after reset. It inverts exactly in the cycles where `out_tick` is high and holds its value in all other cycles.
- R5: A loaded ratio below 240 behaves as 240. A ratio of exactly 240 is used as given.
- R6: A load changes the shadow ratio only. The period in progress completes with the ratio it started with, and the new ratio applies from the next period. When several loads fall inside one period, the last one wins.
- R7: Cycles with `in_tick` low change neither the count nor any output. `out_tick` only follows a sampled input tick.
- R8: Reset is synchronous and active low. After reset `out_tick`, `half_out` and `mod_ctl` are low, and the first period uses the ratio 240.
- R9: The extremes divide correctly: the maximum ratio 32767, and ratios where A equals M so that every prescaler period uses modulus 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_tick | input | 1 | One input event to be divided (clock enable) |
| ratio_word | input | 15 | Requested ratio, M in bits [14:4], A in bits [3:0] |
| load | input | 1 | Captures `ratio_word` into the shadow ratio |
| out_tick | output | 1 | One-cycle pulse per divided period |
| half_out | output | 1 | Output tick rate divided by two, as a square wave |
| mod_ctl | output | 1 | High while the prescaler divides by 17 |

## Verification
Each output period is measured in input ticks, and the count is compared against 16·M + A for a pseudo-random set of ratios, with idle gaps between input ticks. This separates true tick counting from cycle counting and exposes a swapped or shifted M/A split. A ratio with A = 0 and a ratio with A = M isolate the modulus-17 phase at each of its ends, while the maximum ratio exercises the full width of the M counter. Ratios of 0, 17, 239 and exactly 240 distinguish the floor from an off-by-one comparison. A load issued in the middle of a period shows whether the period in progress is truncated or the new ratio is applied late.

// File: rtl/psd_pkg.sv
// Package: shared defaults for the pulse-swallow divider.
// Assumes nothing beyond a 16/17 prescaler built from an A_W-bit swallow field.
package psd_pkg;
    localparam int DEF_A_W       = 4;
    localparam int DEF_M_W       = 11;
    localparam int DEF_MIN_RATIO = 240;

    // Prescaler modulus selection
    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by 2**A_W
        MOD_PLUS = 1'b1    // divide by 2**A_W + 1
    } modsel_e;
endpackage

// File: rtl/psd_ratio_shadow.sv
// Ratio shadow: clamps a requested ratio to the legal floor and holds it
// until the counters reload at the end of a period.
// Assumes MIN_RATIO >= 2**A_W * (2**A_W - 1), so the clamped value always has A <= M.
module psd_ratio_shadow #(
    parameter int A_W       = psd_pkg::DEF_A_W,
    parameter int M_W       = psd_pkg::DEF_M_W,
    parameter int MIN_RATIO = psd_pkg::DEF_MIN_RATIO
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W+M_W-1:0] ratio_in,
    output logic [M_W-1:0] m_sh,
    output logic [A_W-1:0] a_sh
);
    localparam int RW = A_W + M_W;
    localparam logic [RW-1:0] FLOOR = RW'(MIN_RATIO);

    logic [RW-1:0] clamped;
    logic [RW-1:0] shadow_q;

    // Raise too-small ratios to the floor
    always_comb begin
        clamped = (ratio_in < FLOOR) ? FLOOR : ratio_in;
    end

    // Capture the clamped ratio on a load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= FLOOR;
        end else if (load) begin
            shadow_q <= clamped;
        end
    end

    assign m_sh = shadow_q[RW-1:A_W];
    assign a_sh = shadow_q[A_W-1:0];
endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler model: counts input ticks and emits one tick
// every 2**P_W ticks, or every 2**P_W + 1 ticks when mod_hi is set.
// Assumes mod_hi changes only on the edge that completes a prescaler period.
module psd_prescaler #(
    parameter int P_W = psd_pkg::DEF_A_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    input  psd_pkg::modsel_e mod_sel,
    output logic pre_tick
);
    localparam int CW = P_W + 1;
    localparam logic [CW-1:0] LAST_BASE = CW'((1 << P_W) - 1);
    localparam logic [CW-1:0] LAST_PLUS = CW'(1 << P_W);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Terminal count for the active modulus
    always_comb begin
        last     = (mod_sel == psd_pkg::MOD_PLUS) ? LAST_PLUS : LAST_BASE;
        pre_tick = in_tick && (cnt_q == last);
    end

    // Advance on each input tick, wrap at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_tick) begin
            cnt_q <= pre_tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/psd_swallow.sv
// Swallow and main counters: count prescaler periods, hold the prescaler
// at the larger modulus for the first A of them, and flag the last one.
// Assumes A <= M and M >= 1 for every reloaded value.
module psd_swallow #(
    parameter int A_W   = psd_pkg::DEF_A_W,
    parameter int M_W   = psd_pkg::DEF_M_W,
    parameter int RST_M = psd_pkg::DEF_MIN_RATIO >> psd_pkg::DEF_A_W,
    parameter int RST_A = psd_pkg::DEF_MIN_RATIO % (1 << psd_pkg::DEF_A_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tick,
    input  logic [M_W-1:0] m_load,
    input  logic [A_W-1:0] a_load,
    output psd_pkg::modsel_e mod_sel,
    output logic           period_end
);
    logic [M_W-1:0] m_rem;
    logic [A_W-1:0] a_rem;

    // Larger modulus while swallow periods remain; detect the final period
    always_comb begin
        mod_sel    = (a_rem != '0) ? psd_pkg::MOD_PLUS : psd_pkg::MOD_BASE;
        period_end = pre_tick && (m_rem == M_W'(1));
    end

    // Count down per prescaler period, reload from the shadow at period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_rem <= M_W'(RST_M);
            a_rem <= A_W'(RST_A);
        end else if (pre_tick) begin
            if (period_end) begin
                m_rem <= m_load;
                a_rem <= a_load;
            end else begin
                m_rem <= m_rem - 1'b1;
                if (a_rem != '0) begin
                    a_rem <= a_rem - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pulse_swallow_div.sv
// Programmable pulse-swallow divider: divides input ticks by 16*M + A,
// with a shadowed ratio applied at period boundaries and a /2 test output.
// Assumes in_tick is synchronous to clk.
module pulse_swallow_div #(
    parameter int A_W       = psd_pkg::DEF_A_W,
    parameter int M_W       = psd_pkg::DEF_M_W,
    parameter int MIN_RATIO = psd_pkg::DEF_MIN_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_tick,
    input  logic [A_W+M_W-1:0] ratio_word,
    input  logic               load,
    output logic               out_tick,
    output logic               half_out,
    output logic               mod_ctl
);
    localparam int RST_M = MIN_RATIO >> A_W;
    localparam int RST_A = MIN_RATIO % (1 << A_W);

    logic [M_W-1:0]   m_sh;
    logic [A_W-1:0]   a_sh;
    psd_pkg::modsel_e mod_sel;
    logic             pre_tick;
    logic             period_end;

    psd_ratio_shadow #(.A_W(A_W), .M_W(M_W), .MIN_RATIO(MIN_RATIO)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ratio_in (ratio_word),
        .m_sh     (m_sh),
        .a_sh     (a_sh)
    );

    psd_prescaler #(.P_W(A_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (in_tick),
        .mod_sel  (mod_sel),
        .pre_tick (pre_tick)
    );

    psd_swallow #(.A_W(A_W), .M_W(M_W), .RST_M(RST_M), .RST_A(RST_A)) u_swl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_tick   (pre_tick),
        .m_load     (m_sh),
        .a_load     (a_sh),
        .mod_sel    (mod_sel),
        .period_end (period_end)
    );

    // Register the period pulse and toggle the halved output on it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tick <= 1'b0;
            half_out <= 1'b0;
        end else begin
            out_tick <= period_end;
            if (period_end) begin
                half_out <= ~half_out;
            end
        end
    end

    assign mod_ctl = (mod_sel == psd_pkg::MOD_PLUS);
endmodule

// File: rtl/psd_checker.sv
// Checker: temporal properties of the divider outputs, bound to the top.
// Assumes the top keeps the floor ratio well above 2, so output pulses never abut.
module psd_checker (
    input logic clk,
    input logic rst_n,
    input logic in_tick,
    input logic out_tick,
    input logic half_out,
    input logic mod_ctl
);
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |=> !out_tick);

    p_tick_after_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> $past(in_tick));

    p_idle_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tick |=> ($stable(mod_ctl) && !out_tick));

    p_half_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> (half_out != $past(half_out)));

    p_half_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tick |-> $stable(half_out));

    p_mod_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> out_tick);

    p_mod_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctl) |-> $past(in_tick));
endmodule

bind pulse_swallow_div psd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_tick  (in_tick),
    .out_tick (out_tick),
    .half_out (half_out),
    .mod_ctl  (mod_ctl)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_tick = 1'b0;
    logic [14:0] ratio_word = '0;
    logic        load = 1'b0;
    logic        out_tick, half_out, mod_ctl;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    pulse_swallow_div u0 (
        .clk(clk), .rst_n(rst_n), .in_tick(in_tick), .ratio_word(ratio_word),
        .load(load), .out_tick(out_tick), .half_out(half_out), .mod_ctl(mod_ctl)
    );

    // Scoreboard: expected ratio and requirement tag per output period
    int    exp_q[$];
    string tag_q[$];

    // Driver-side model state
    int    cur_ratio = 240;
    int    shadow = 240;
    string shadow_tag = "R8";
    int    dcnt = 0;
    int    done_periods = 0;

    function automatic int clamp_ratio(input int r);
        return (r < 240) ? 240 : r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle of stimulus; the model advances on each driven tick
    task automatic step(input bit tk);
        @(negedge clk); #1;
        in_tick = tk;
        load = 1'b0;
        if (tk) begin
            dcnt++;
            if (dcnt == cur_ratio) begin
                dcnt = 0;
                done_periods++;
                cur_ratio = shadow;
                exp_q.push_back(cur_ratio);
                tag_q.push_back(shadow_tag);
            end
        end
    endtask

    task automatic do_load(input int r, input string tag);
        @(negedge clk); #1;
        in_tick = 1'b0;
        load = 1'b1;
        ratio_word = 15'(r);
        shadow = clamp_ratio(r);
        shadow_tag = tag;
    endtask

    task automatic run_periods(input int n, input int idle_pct);
        int target;
        target = done_periods + n;
        while (done_periods < target) step(($urandom % 100) >= idle_pct);
    endtask

    task automatic run_ticks(input int n, input int idle_pct);
        int got;
        got = 0;
        while (got < n) begin
            if (($urandom % 100) >= idle_pct) begin
                step(1'b1);
                got++;
            end else begin
                step(1'b0);
            end
        end
    endtask

    // Monitor: counts ticks per period, checks the period, /2 output and modulus control
    int  mcnt = 0;
    logic prev_half = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mcnt = 0;
            prev_half = 1'b0;
        end else begin
            if (in_tick) mcnt++;
            if (out_tick) begin
                check(in_tick === 1'b1, "R7 out_tick follows an input tick", out_tick, 1);
                if (exp_q.size() > 0) begin
                    check(mcnt == exp_q[0], {tag_q[0], "/R1 period length"}, mcnt, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end else begin
                    check(1'b0, "R1 unexpected output tick", 1, 0);
                end
                check(half_out != prev_half, "R4 half_out toggles", half_out, !prev_half);
                mcnt = 0;
            end else begin
                check(half_out == prev_half, "R4 half_out holds", half_out, prev_half);
            end
            prev_half = half_out;
            if (exp_q.size() > 0) begin
                check(mod_ctl == (mcnt < 17 * (exp_q[0] % 16)), "R2 modulus control",
                      mod_ctl, (mcnt < 17 * (exp_q[0] % 16)));
            end
        end
    end

    initial begin
        exp_q.push_back(240);
        tag_q.push_back("R8");
        repeat (4) @(negedge clk);
        check(out_tick == 1'b0, "R8 out_tick in reset", out_tick, 0);
        check(half_out == 1'b0, "R8 half_out in reset", half_out, 0);
        check(mod_ctl == 1'b0, "R8 mod_ctl in reset", mod_ctl, 0);
        #1 rst_n = 1'b1;

        // R6: load mid-period; the first period keeps the reset ratio
        run_ticks(100, 20);
        do_load(1000, "R6");
        run_periods(3, 20);
        // R6: two loads in one period, last wins
        run_ticks(50, 0);
        do_load(3000, "R6");
        run_ticks(10, 0);
        do_load(1234, "R6");
        run_periods(3, 10);
        // R5: floor
        do_load(17, "R5");
        run_periods(2, 0);
        do_load(0, "R5");
        run_periods(2, 30);
        do_load(239, "R5");
        run_periods(2, 0);
        do_load(240, "R5");
        run_periods(2, 0);
        // R9: A equals M, then maximum ratio
        do_load(16 * 15 + 15, "R9");
        run_periods(3, 0);
        do_load(16 * 100 + 100 % 16, "R9");
        run_periods(2, 0);
        do_load(32767, "R9");
        run_periods(2, 0);
        // R1 and R7: random ratios with idle gaps
        for (int i = 0; i < 8; i++) begin
            do_load($urandom_range(4095, 240), "R1");
            run_periods(2, 25);
        end
        repeat (4) step(1'b0);
        check(exp_q.size() == 1, "R1 all periods observed", exp_q.size(), 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (198000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule